// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Latched Change Interrupts

This block is the pin-side core of a small general-purpose I/O expander. A host reaches it through a plain register bus that has an address, write data, a write strobe, a read strobe and combinational read data. Through that bus the host sets each pin's direction, its output value and the output style. Output style is either push-pull or open-drain, and one bit selects it for the whole port. The host also chooses per pin whether the input is inverted, whether an input change is latched, and whether a change may raise the interrupt.

Pin inputs pass through a two-flop synchroniser. The block compares each input pin against a reference. The reference is the value the host saw the last time it read the input register. An unmasked mismatch sets the pin's status bit and pulls the active-low, open-drain interrupt line. The block models that line as a single output enable that drives low.

A pin with latching enabled freezes the first differing value in the input register. That value stays until the host reads it, even if the pin returns to its old level. A pin without latching drops its status as soon as it returns to the reference.

The bus has no back-pressure: every strobe is accepted in the cycle it is seen. A read's side effect (clearing status) takes place at the clock edge that ends the read cycle.

Top module: `gpio_latch_port`

## Requirements
- R1: After reset, the direction register reads 0xFF (all inputs) and the interrupt mask reads 0xFF (all masked). Output, polarity, latch-enable and mode read 0, status reads 0, no pin is driven and the interrupt enable is low.
- R2: Register indices sit in address bits [2:0] and every higher address bit must be zero. The indices are: 0 input (read only), 1 output, 2 polarity, 3 direction (1 = input), 4 latch enable, 5 mask (1 = masked), 6 status (read only), 7 mode (bit 0 = 1 selects open-drain). Writable registers read back what was written. A read at an address with any high bit set returns 0.
- R3: The input register bit equals the synchronised pin XOR the polarity bit. A pin change becomes visible after two rising clock edges.
- R4: An input-direction, unmasked pin whose input value differs from its reference sets its status bit, and the interrupt enable goes high.
- R5: A masked pin never sets status and never raises the interrupt.
- R6: A read of the input register loads each reference with the value returned and clears latched status. With stable pins, the interrupt is released in the cycle after the read.
- R7: For a pin without latching, status clears by itself when the input value returns to the reference.
- R8: For a pin with latching, the first differing value is held in the input register, and its status stays set, until the input register is read, even if the pin reverts.
- R9: In push-pull mode, an output-direction pin has its enable high and drives its output register bit. An input-direction pin is never driven.
- R10: In open-drain mode, an output pin whose output bit is 0 is driven low. An output pin whose output bit is 1 is released (enable low).
- R11: Output-direction pins never set status, whatever their pin level does.
- R12: Writes to the input register, the status register, or any address with a high bit set change no register.
- R13: Asserting the reset input mid-operation immediately returns every register to its R1 value and releases the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register address |
| bus_wdata | input | W (8) | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; status side effects at the closing edge |
| bus_rdata | output | W (8) | Read data, combinational from the address |
| pin_i | input | W (8) | Asynchronous pin levels |
| pin_o | output | W (8) | Pin output values |
| pin_oe | output | W (8) | Pin output enables |
| irq_oe | output | 1 | High when the active-low interrupt line is pulled low |

## Verification
The assertions assume the bus strobes change only between clock edges. They also assume that a cycle holding an input read or a write is not used to reason about latched-pin stability, so the hold check is enabled only in cycles with neither strobe. The pins may move at any time because the synchroniser absorbs them. The stimulus drives every input a little after the falling edge and issues one strobe per operation, with an idle cycle between operations. A reset pulse is also placed in mid-cycle to exercise the asynchronous path.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    RI_INPUT  = 3'd0,
    RI_OUTPUT = 3'd1,
    RI_POLAR  = 3'd2,
    RI_DIR    = 3'd3,
    RI_LATCH  = 3'd4,
    RI_MASK   = 3'd5,
    RI_STATUS = 3'd6,
    RI_MODE   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ok,
  input  reg_idx_e     widx,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] mask_q,
  output logic         od_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      pol_q  <= '0;
      dir_q  <= '1;
      lat_q  <= '0;
      mask_q <= '1;
      od_q   <= 1'b0;
    end else if (wr_ok) begin
      case (widx)
        RI_OUTPUT: out_q  <= wdata;
        RI_POLAR:  pol_q  <= wdata;
        RI_DIR:    dir_q  <= wdata;
        RI_LATCH:  lat_q  <= wdata;
        RI_MASK:   mask_q <= wdata;
        RI_MODE:   od_q   <= wdata[0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_capture.sv
module gpio_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] lat,
  input  logic [W-1:0] mask,
  input  logic         rd_input,
  output logic [W-1:0] view,
  output logic [W-1:0] status
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic cur;
    logic diff;
    logic ref_r;
    logic held_r;
    logic hval_r;

    assign cur       = pin_s[b] ^ pol[b];
    assign diff      = dir[b] & (cur ^ ref_r);
    assign view[b]   = held_r ? hval_r : cur;
    assign status[b] = ~mask[b] & dir[b] & (lat[b] ? held_r : diff);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_r  <= 1'b0;
        held_r <= 1'b0;
        hval_r <= 1'b0;
      end else begin
        held_r <= lat[b] & ~rd_input & (held_r | diff);
        hval_r <= held_r ? hval_r : cur;
        if (rd_input) ref_r <= view[b];
      end
    end
  end
endmodule

// File: rtl/gpio_latch_port.sv
module gpio_latch_port
  import gpio_port_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe,
  output logic              irq_oe
);
  logic           hit;
  reg_idx_e       idx;
  logic           wr_ok;
  logic           rd_input;
  logic [W-1:0]   pin_s;
  logic [W-1:0]   out_q, pol_q, dir_q, lat_q, mask_q;
  logic           od_q;
  logic [W-1:0]   in_view;
  logic [W-1:0]   status;

  assign hit      = (bus_addr[ADDR_W-1:IDX_W] == '0);
  assign idx      = reg_idx_e'(bus_addr[IDX_W-1:0]);
  assign wr_ok    = bus_wr & hit;
  assign rd_input = bus_rd & hit & (idx == RI_INPUT);

  gpio_sync2 #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .widx(idx), .wdata(bus_wdata),
    .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q), .lat_q(lat_q),
    .mask_q(mask_q), .od_q(od_q)
  );

  gpio_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .pol(pol_q), .dir(dir_q),
    .lat(lat_q), .mask(mask_q), .rd_input(rd_input),
    .view(in_view), .status(status)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (idx)
        RI_INPUT:  bus_rdata = in_view;
        RI_OUTPUT: bus_rdata = out_q;
        RI_POLAR:  bus_rdata = pol_q;
        RI_DIR:    bus_rdata = dir_q;
        RI_LATCH:  bus_rdata = lat_q;
        RI_MASK:   bus_rdata = mask_q;
        RI_STATUS: bus_rdata = status;
        RI_MODE:   bus_rdata = {{(W-1){1'b0}}, od_q};
        default:   bus_rdata = '0;
      endcase
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_pin
    assign pin_o[b]  = od_q ? 1'b0 : out_q[b];
    assign pin_oe[b] = ~dir_q[b] & (od_q ? ~out_q[b] : 1'b1);
  end

  assign irq_oe = |status;
endmodule

// File: rtl/gpio_latch_port_chk.sv
module gpio_latch_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_ok,
  input logic         rd_input,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] out_q,
  input logic [W-1:0] lat_q,
  input logic [W-1:0] mask_q,
  input logic         od_q,
  input logic [W-1:0] in_view,
  input logic [W-1:0] status,
  input logic [W-1:0] pin_oe,
  input logic         irq_oe
);
  // R1: first cycle out of reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && !irq_oe));

  // R9: input-direction pins are never driven
  a_r9_inputs_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir_q) == '0);

  // R10: in open-drain mode only zero output bits are driven
  a_r10_od_drives_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    od_q |-> ((pin_oe & out_q) == '0));

  // R5: the interrupt needs an unmasked input pin
  a_r5_irq_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> ((~mask_q & dir_q) != '0));

  // R8: a latched, flagged pin keeps its input value until a read
  a_r8_latched_value_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_input && !wr_ok) |=>
      (((in_view ^ $past(in_view)) & $past(lat_q & status) & lat_q) == '0));
endmodule

bind gpio_latch_port gpio_latch_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_input(rd_input),
  .dir_q(dir_q), .out_q(out_q), .lat_q(lat_q), .mask_q(mask_q), .od_q(od_q),
  .in_view(in_view), .status(status), .pin_oe(pin_oe), .irq_oe(irq_oe)
);

// File: tb/gpio_latch_port_test.sv
module gpio_latch_port_test;
  localparam int PERIOD = 10;
  localparam int W      = 8;
  localparam int AW     = 8;

  logic          clk   = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr  = '0;
  logic [W-1:0]  wdata = '0;
  logic          wr    = 1'b0;
  logic          rd    = 1'b0;
  logic [W-1:0]  pins  = '0;
  logic [W-1:0]  rdata, pin_o, pin_oe;
  logic          irq;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string phase  = "R1";

  // reference model state
  logic [W-1:0] m_dir, m_out, m_pol, m_lat, m_mask, m_s1, m_s2, m_ref, m_held, m_hval;
  logic         m_od;

  gpio_latch_port #(.W(W), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata), .pin_i(pins),
    .pin_o(pin_o), .pin_oe(pin_oe), .irq_oe(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] m_view();
    return (m_held & m_hval) | (~m_held & (m_s2 ^ m_pol));
  endfunction

  function automatic logic [W-1:0] m_status();
    logic [W-1:0] diff;
    diff = m_dir & ((m_s2 ^ m_pol) ^ m_ref);
    return ~m_mask & m_dir & ((m_lat & m_held) | (~m_lat & diff));
  endfunction

  function automatic logic [W-1:0] m_rdata();
    if (addr[AW-1:3] != '0) return '0;
    case (addr[2:0])
      3'd0: return m_view();
      3'd1: return m_out;
      3'd2: return m_pol;
      3'd3: return m_dir;
      3'd4: return m_lat;
      3'd5: return m_mask;
      3'd6: return m_status();
      default: return {{(W-1){1'b0}}, m_od};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '1; m_mask = '1; m_out = '0; m_pol = '0; m_lat = '0; m_od = 1'b0;
      m_s1 = '0; m_s2 = '0; m_ref = '0; m_held = '0; m_hval = '0;
    end else begin
      logic         hit, rdi;
      logic [W-1:0] diff, view, nheld, nhval;
      hit   = (addr[AW-1:3] == '0);
      rdi   = rd && hit && (addr[2:0] == 3'd0);
      view  = m_view();
      diff  = m_dir & ((m_s2 ^ m_pol) ^ m_ref);
      nheld = rdi ? '0 : (m_lat & (m_held | diff));
      nhval = (m_held & m_hval) | (~m_held & (m_s2 ^ m_pol));
      if (rdi) m_ref = view;
      m_held = nheld;
      m_hval = nhval;
      if (wr && hit) begin
        case (addr[2:0])
          3'd1: m_out  = wdata;
          3'd2: m_pol  = wdata;
          3'd3: m_dir  = wdata;
          3'd4: m_lat  = wdata;
          3'd5: m_mask = wdata;
          3'd7: m_od   = wdata[0];
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pins;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk({phase, " rdata"}, rdata, m_rdata());
      chk({phase, " R4 irq"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, (m_status() != '0)});
      chk({phase, " R9 pin_oe"}, pin_oe, m_od ? (~m_dir & ~m_out) : ~m_dir);
      chk({phase, " R10 pin_o"}, pin_o, m_od ? '0 : m_out);
    end
  end

  task automatic wr_reg(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk); #1 addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); #1 wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, input logic [W-1:0] exp, input string tag);
    @(negedge clk); #1 addr = a; rd = 1'b1;
    #2 chk(tag, rdata, exp);
    @(negedge clk); #1 rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic [W-1:0] v);
    @(negedge clk); #1 pins = v;
  endtask

  task automatic chk_now(input string tag, input logic act, input logic exp);
    @(negedge clk); #2 chk(tag, {{(W-1){1'b0}}, act}, {{(W-1){1'b0}}, exp});
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    phase = "R1";
    idle(3);
    @(negedge clk); #1 rst_n = 1'b1;
    rd_reg(8'h03, 8'hFF, "R1 direction");
    rd_reg(8'h05, 8'hFF, "R1 mask");
    rd_reg(8'h06, 8'h00, "R1 status");
    rd_reg(8'h01, 8'h00, "R1 output");
    chk_now("R1 irq", irq, 1'b0);

    phase = "R2";
    wr_reg(8'h01, 8'h3C);
    rd_reg(8'h01, 8'h3C, "R2 output readback");
    wr_reg(8'h07, 8'h01);
    rd_reg(8'h07, 8'h01, "R2 mode readback");
    wr_reg(8'h07, 8'h00);
    rd_reg(8'h40, 8'h00, "R2 undefined address");

    phase = "R12";
    wr_reg(8'h41, 8'hFF);
    rd_reg(8'h01, 8'h3C, "R12 high-bit write ignored");
    wr_reg(8'h00, 8'hFF);
    wr_reg(8'h06, 8'hFF);
    rd_reg(8'h06, 8'h00, "R12 status write ignored");
    rd_reg(8'h00, 8'h00, "R12 input write ignored");

    phase = "R3";
    set_pins(8'hA5);
    idle(3);
    rd_reg(8'h00, 8'hA5, "R3 input value");
    wr_reg(8'h02, 8'h0F);
    rd_reg(8'h00, 8'hAA, "R3 polarity");
    wr_reg(8'h02, 8'h00);

    phase = "R5";
    set_pins(8'h5A);
    idle(4);
    chk_now("R5 masked irq", irq, 1'b0);
    rd_reg(8'h06, 8'h00, "R5 masked status");
    rd_reg(8'h00, 8'h5A, "R5 input");

    phase = "R4";
    wr_reg(8'h05, 8'hF0);
    idle(2);
    set_pins(8'h5B);
    idle(4);
    chk_now("R4 irq raised", irq, 1'b1);
    rd_reg(8'h06, 8'h01, "R4 status");

    phase = "R6";
    rd_reg(8'h00, 8'h5B, "R6 input read");
    chk_now("R6 irq released", irq, 1'b0);
    rd_reg(8'h06, 8'h00, "R6 status cleared");

    phase = "R7";
    set_pins(8'h5F);
    idle(4);
    rd_reg(8'h06, 8'h04, "R7 status set");
    set_pins(8'h5B);
    idle(4);
    rd_reg(8'h06, 8'h00, "R7 status self-cleared");

    phase = "R8";
    wr_reg(8'h04, 8'h02);
    set_pins(8'h59);
    idle(4);
    set_pins(8'h5B);
    idle(4);
    rd_reg(8'h06, 8'h02, "R8 status held");
    rd_reg(8'h00, 8'h59, "R8 held value");
    rd_reg(8'h00, 8'h5B, "R8 new capture");
    idle(2);
    rd_reg(8'h06, 8'h00, "R8 cleared");

    phase = "R11";
    wr_reg(8'h04, 8'h00);
    wr_reg(8'h03, 8'hF0);
    wr_reg(8'h01, 8'h05);
    set_pins(8'h50);
    idle(4);
    chk_now("R11 no irq", irq, 1'b0);
    rd_reg(8'h06, 8'h00, "R11 status");

    phase = "R9";
    @(negedge clk); #2 chk("R9 enables", pin_oe, 8'h0F);
    chk("R9 values", pin_o, 8'h05);

    phase = "R10";
    wr_reg(8'h07, 8'h01);
    @(negedge clk); #2 chk("R10 open-drain enables", pin_oe, 8'h0A);
    chk("R10 open-drain values", pin_o, 8'h00);
    wr_reg(8'h01, 8'h0A);
    @(negedge clk); #2 chk("R10 open-drain enables 2", pin_oe, 8'h05);

    phase = "R13";
    wr_reg(8'h05, 8'h00);
    wr_reg(8'h03, 8'hFF);
    idle(1);
    chk_now("R13 irq before reset", irq, 1'b1);
    @(negedge clk); #3 rst_n = 1'b0;
    #1 chk("R13 irq on reset", {{(W-1){1'b0}}, irq}, '0);
    chk("R13 pins on reset", pin_oe, '0);
    idle(2);
    @(negedge clk); #1 rst_n = 1'b1;
    rd_reg(8'h05, 8'hFF, "R13 mask");
    rd_reg(8'h07, 8'h00, "R13 mode");
    rd_reg(8'h01, 8'h00, "R13 output");

    idle(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule